// File: doc/BRIEF.md
# Serial Link Slave Responder

This block is the slave end of a full-duplex synchronous serial link that moves 26-bit words. An external master drives an active-low select line, a serial clock and a serial data line. Once the slave sees select held low, it takes in the master's command word one bit per falling serial clock edge. At the same time it sends back a response word, one bit per rising edge. Both words travel most significant bit first.

All three serial inputs are brought into the system clock domain through a two-flop synchronizer. Serial clock edges are found by comparing successive synchronized samples, so the system clock must run at four or more times the serial clock rate. The serial clock may run freely between frames. The block ignores it unless select is low and a frame is still open.

A completed command word appears on a parallel port together with a one-cycle valid strobe. The next response word is taken from a parallel input. It is loaded while select is high, and also on the first rising serial edge after a frame has completed.

Top module: `sslink_resp`

## Requirements
- R1: A frame holds 26 bits taken from `sdata_i` on falling `sclk_i` edges, most significant bit first. After the 26th bit, `cmd_word_o` carries the word with the first received bit at bit 25. `cmd_word_o` changes only together with a valid strobe.
- R2: The response word leaves on `sdata_o` most significant bit first. Bit 25 is present before the first rising serial edge that follows the first falling edge of the frame. Each later rising edge, up to the 26th, moves the line to the next lower bit.
- R3: Input bits are sampled only on falling serial edges. A master that changes `sdata_i` on rising edges is therefore received without skew.
- R4: While `sel_ni` is high, serial clock and data activity produces no strobe and leaves `cmd_word_o` unchanged. Within three system cycles, `sdata_o` follows bit 25 of `rsp_word_i`.
- R5: `cmd_valid_o` is high for exactly one system cycle. It is high in the third system cycle after the input edge on `sclk_i` that ends the 26th bit. In the two cycles before that it is low.
- R6: If `sel_ni` goes high before 26 bits have been received, the partial frame is discarded with no strobe and no change of `cmd_word_o`. The next frame starts again from bit 25.
- R7: After 26 bits, further serial edges are ignored while `sel_ni` stays low, so there is no second strobe. The first rising edge after completion loads `rsp_word_i`, and `sdata_o` then shows its bit 25.
- R8: While `rst_ni` is low, `cmd_word_o` is zero, `cmd_valid_o` is low and `sdata_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| sel_ni | input | 1 | Active-low frame select from the master |
| sdata_i | input | 1 | Serial command data from the master |
| sdata_o | output | 1 | Serial response data to the master |
| rsp_word_i | input | 26 | Next response word |
| cmd_word_o | output | 26 | Last complete command word |
| cmd_valid_o | output | 1 | One-cycle strobe marking a new command word |

## Verification
Each serial input passes through two synchronizer flops, and edges are detected one stage later. The strobe and the new command word are therefore due in the third system cycle after the 26th falling serial edge. The bench samples that cycle and the two cycles before it at the falling system clock edge. A response bit moved by a rising serial edge settles after three system cycles. The bench reads it only just before the next rising serial edge, eight cycles later, which is also when a master would latch it. Checks for ignored activity read `cmd_word_o`, a strobe counter and `sdata_o` once the serial activity has ended, and before the next frame starts.

// File: rtl/sslink_pkg.sv
package sslink_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } frame_st_e;

  localparam int unsigned SIG_SCLK = 0;
  localparam int unsigned SIG_SEL  = 1;
  localparam int unsigned SIG_DATA = 2;
  localparam int unsigned NUM_SIG  = 3;
endpackage

// File: rtl/sslink_sync.sv
module sslink_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_sig
    logic [DEPTH-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {DEPTH{RST_VAL[g]}};
      else         chain_q <= {chain_q[DEPTH-2:0], async_i[g]};
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/sslink_rx.sv
module sslink_rx
  import sslink_pkg::*;
#(
  parameter int unsigned W = 26
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_lvl_i,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         data_lvl_i,
  output logic         shift_en_o,
  output logic         load_en_o,
  output logic [W-1:0] cmd_word_o,
  output logic         cmd_valid_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  frame_st_e      state_q;
  logic [CW-1:0]  bit_cnt_q;
  logic [W-1:0]   rx_sh_q;
  logic           open_frame;
  logic [W-1:0]   rx_next;

  assign open_frame = !sel_lvl_i && (state_q != ST_DONE);
  assign rx_next    = {rx_sh_q[W-2:0], data_lvl_i};
  // no shift before the first capture: bit 25 is already on the line
  assign shift_en_o = sclk_rise_i && open_frame && (bit_cnt_q != '0);
  assign load_en_o  = sel_lvl_i || (sclk_rise_i && state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      cmd_word_o  <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (sel_lvl_i) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
      end else if (open_frame) begin
        state_q <= ST_SHIFT;
        if (sclk_fall_i) begin
          rx_sh_q <= rx_next;
          if (bit_cnt_q == LAST) begin
            bit_cnt_q   <= '0;
            cmd_word_o  <= rx_next;
            cmd_valid_o <= 1'b1;
            state_q     <= ST_DONE;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
      end
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_lvl_i |=> !cmd_valid_o);
  // R6
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_lvl_i |=> (bit_cnt_q == '0));
  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q < CW'(W));
  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> !cmd_valid_o);
  // R1
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_word_o != $past(cmd_word_o)) |-> cmd_valid_o);
endmodule

// File: rtl/sslink_tx.sv
module sslink_tx #(
  parameter int unsigned W = 26
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_en_i,
  input  logic         shift_en_i,
  input  logic [W-1:0] rsp_word_i,
  output logic         sdata_o
);
  logic [W-1:0] tx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tx_sh_q <= '0;
    else if (load_en_i)  tx_sh_q <= rsp_word_i;
    else if (shift_en_i) tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
  end

  assign sdata_o = tx_sh_q[W-1];

  // R4
  idle_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> (sdata_o == $past(rsp_word_i[W-1])));
  // R2
  hold_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !shift_en_i) |=> $stable(sdata_o));
endmodule

// File: rtl/sslink_resp.sv
module sslink_resp
  import sslink_pkg::*;
#(
  parameter int unsigned W           = 26,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         sel_ni,
  input  logic         sdata_i,
  output logic         sdata_o,
  input  logic [W-1:0] rsp_word_i,
  output logic [W-1:0] cmd_word_o,
  output logic         cmd_valid_o
);
  localparam logic [NUM_SIG-1:0] SYNC_RST = NUM_SIG'(1) << SIG_SEL;

  logic [NUM_SIG-1:0] raw, lvl, rise, fall;
  logic shift_en, load_en;

  assign raw[SIG_SCLK] = sclk_i;
  assign raw[SIG_SEL]  = sel_ni;
  assign raw[SIG_DATA] = sdata_i;

  sslink_sync #(.N(NUM_SIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .async_i(raw),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  sslink_rx #(.W(W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_lvl_i  (lvl[SIG_SEL]),
    .sclk_rise_i(rise[SIG_SCLK]),
    .sclk_fall_i(fall[SIG_SCLK]),
    .data_lvl_i (lvl[SIG_DATA]),
    .shift_en_o (shift_en),
    .load_en_o  (load_en),
    .cmd_word_o (cmd_word_o),
    .cmd_valid_o(cmd_valid_o)
  );

  sslink_tx #(.W(W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_en_i (load_en),
    .shift_en_i(shift_en),
    .rsp_word_i(rsp_word_i),
    .sdata_o   (sdata_o)
  );
endmodule

// File: tb/sslink_resp_tb.sv
module sslink_resp_tb_top;
  localparam int W    = 26;
  localparam int HALF = 4;
  localparam int NV   = 5;
  localparam logic [W-1:0] CMD_TAB [NV] = '{26'h3FFFFFF, 26'h0000000, 26'h2AAAAAA, 26'h1555555, 26'h2F0C3A5};
  localparam logic [W-1:0] RSP_TAB [NV] = '{26'h1555555, 26'h2AAAAAA, 26'h0000000, 26'h3FFFFFF, 26'h18E7C01};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, sel_n = 1'b1, mosi = 1'b0;
  logic [W-1:0] rsp_word = '0;
  logic miso, valid;
  logic [W-1:0] cmd_word;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  sslink_resp dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk), .sel_ni(sel_n),
    .sdata_i(mosi), .sdata_o(miso), .rsp_word_i(rsp_word),
    .cmd_word_o(cmd_word), .cmd_valid_o(valid)
  );

  always @(negedge clk_i) if (rst_ni && valid) pulses++;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [W-1:0] cmd, input logic [W-1:0] nxt,
                           input int nbits, input int extra,
                           output logic [W-1:0] got, output logic nxt_msb);
    got = '0;
    nxt_msb = 1'b0;
    @(negedge clk_i);
    sclk = 1'b1; sel_n = 1'b0; mosi = cmd[W-1];
    for (int i = 0; i < nbits; i++) begin
      repeat (HALF) @(negedge clk_i);
      sclk = 1'b0;
      if (i == 0) rsp_word = nxt;
      if (i == W-1) begin
        @(negedge clk_i); chk(valid == 1'b0, "R5 early cycle 1", W'(valid), '0);
        @(negedge clk_i); chk(valid == 1'b0, "R5 early cycle 2", W'(valid), '0);
        @(negedge clk_i); chk(valid == 1'b1, "R5 strobe cycle 3", W'(valid), 1);
        @(negedge clk_i); chk(valid == 1'b0, "R5 strobe width", W'(valid), '0);
      end else begin
        repeat (HALF) @(negedge clk_i);
      end
      got[W-1-i] = miso;
      if (nbits == W) begin
        sclk = 1'b1;
        mosi = (i < W-1) ? cmd[W-2-i] : ~mosi;
      end else if (i < nbits-1) begin
        sclk = 1'b1;
        mosi = cmd[W-2-i];
      end
    end
    if (nbits == W) begin
      for (int e = 0; e < extra; e++) begin
        repeat (HALF) @(negedge clk_i); sclk = 1'b0; mosi = ~mosi;
        repeat (HALF) @(negedge clk_i); sclk = 1'b1;
      end
      repeat (HALF) @(negedge clk_i);
      nxt_msb = miso;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk_i);
    end
    sel_n = 1'b1;
    repeat (3*HALF) @(negedge clk_i);
  endtask

  initial begin
    logic [W-1:0] got, wsave;
    logic nmsb;
    int p0;
    rsp_word = RSP_TAB[0];
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk(cmd_word == '0, "R8 word in reset", cmd_word, '0);
    chk(valid == 1'b0, "R8 strobe in reset", W'(valid), '0);
    chk(miso == 1'b0, "R8 line in reset", W'(miso), '0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(miso == RSP_TAB[0][W-1], "R4 idle line after reset", W'(miso), W'(RSP_TAB[0][W-1]));

    // table walk: R1 R2 R3 R5 R7
    for (int k = 0; k < NV; k++) begin
      p0 = pulses;
      run_frame(CMD_TAB[k], RSP_TAB[(k+1)%NV], W, 0, got, nmsb);
      chk(cmd_word == CMD_TAB[k], "R1 R3 received word", cmd_word, CMD_TAB[k]);
      chk(pulses == p0 + 1, "R5 one strobe per frame", W'(pulses - p0), 1);
      chk(got == RSP_TAB[k], "R2 response bits", got, RSP_TAB[k]);
      chk(nmsb == RSP_TAB[(k+1)%NV][W-1], "R7 next msb after frame", W'(nmsb), W'(RSP_TAB[(k+1)%NV][W-1]));
    end

    // R4 idle activity ignored
    wsave = cmd_word; p0 = pulses;
    rsp_word = 26'h2000000;
    for (int t = 0; t < 20; t++) begin
      repeat (HALF) @(negedge clk_i); sclk = 1'b1; mosi = t[0];
      repeat (HALF) @(negedge clk_i); sclk = 1'b0;
    end
    repeat (3*HALF) @(negedge clk_i);
    chk(pulses == p0, "R4 no strobe while idle", W'(pulses - p0), '0);
    chk(cmd_word == wsave, "R4 word kept while idle", cmd_word, wsave);
    chk(miso == 1'b1, "R4 idle line msb high", W'(miso), 1);
    rsp_word = 26'h1FFFFFF;
    repeat (3) @(negedge clk_i);
    chk(miso == 1'b0, "R4 idle line follows input", W'(miso), '0);

    // R6 aborted frame then a full one
    wsave = cmd_word; p0 = pulses;
    run_frame(26'h2BCDE01, 26'h1FFFFFF, 10, 0, got, nmsb);
    chk(pulses == p0, "R6 no strobe on abort", W'(pulses - p0), '0);
    chk(cmd_word == wsave, "R6 word kept on abort", cmd_word, wsave);
    run_frame(26'h0C3F00F, 26'h2000000, W, 0, got, nmsb);
    chk(cmd_word == 26'h0C3F00F, "R6 frame after abort", cmd_word, 26'h0C3F00F);
    chk(got == 26'h1FFFFFF, "R6 response restarts at msb", got, 26'h1FFFFFF);

    // R7 extra edges after completion
    p0 = pulses;
    run_frame(26'h1234567, 26'h3000001, W, 6, got, nmsb);
    chk(pulses == p0 + 1, "R7 single strobe with extra edges", W'(pulses - p0), 1);
    chk(cmd_word == 26'h1234567, "R7 word not disturbed", cmd_word, 26'h1234567);
    chk(got == 26'h2000000, "R7 response bits", got, 26'h2000000);
    chk(nmsb == 1'b1, "R7 next word loaded", W'(nmsb), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule